// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Dual DAC Register

This block is the digital front end for a two-channel 12-bit converter that is loaded from an 8-bit processor bus. Each channel has a 12-bit staging register and a 12-bit output register. The staging register is written in two pieces: a low byte and a high nibble. An active-low update strobe copies both staging registers into both output registers together. As a result, both channels change at the same moment, and the order in which the bytes are written does not matter.

All bus and strobe pins are asynchronous to the block clock, so each one passes through a two-stage synchronizer before use. The staging registers behave as transparent latches modelled on the clock: while select and write are both low, the addressed piece follows the data bus. While the update strobe is low, the output registers follow the staging registers.

An update can overlap a write. For that case a parameterised guard window keeps the outputs tracking for a minimum number of cycles after the overlap, so that the final data written is captured even when the strobe is released early.

Top module: `dual_dac_regs`

## Requirements
- R1: The two-bit address selects the piece written: 00 is channel A bits 7..0, 01 is channel A bits 11..8, 10 is channel B bits 7..0 and 11 is channel B bits 11..8.
- R2: While select and write are both low, the addressed staging piece follows the data bus. If the data changes during one write, the last value is kept after select or write goes high.
- R3: A high-nibble write takes data bits 3..0 only. Data bits 7..4 are ignored for it.
- R4: While select or write is high, neither staging register changes, whatever the address and data lines do.
- R5: The low and high pieces may be written in either order. While the update strobe is high, writes leave both outputs unchanged.
- R6: Once the update strobe has gone high and the guard window has expired, both outputs hold their values until the strobe next goes low.
- R7: While the update strobe is low, each output follows its staging register. A pin change reaches the output within four clock cycles: two synchronizer stages, the staging register and the output register.
- R8: Reset clears both outputs and both staging registers to zero.
- R9: If the update strobe is low during a write, the outputs keep tracking for MIN_UPD_CYC cycles after the last such overlapping cycle. The data value written last is therefore captured even if the strobe rises together with the end of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_n | input | 1 | Active-low chip select, asynchronous |
| bus_wr_n | input | 1 | Active-low write strobe, asynchronous |
| bus_addr | input | 2 | Piece select (see R1) |
| bus_data | input | 8 | Right-justified data bus |
| upd_n | input | 1 | Active-low simultaneous update strobe, asynchronous |
| chan_a | output | 12 | Channel A output register |
| chan_b | output | 12 | Channel B output register |

## Verification
Both channels are loaded in opposite byte orders with the strobe held high. This separates order independence and output isolation from a design that passes writes straight through. High-nibble writes carry ones in data bits 7..4, which exposes any leak of the upper bits. Writes with only one of select or write low show whether the strobes are gated correctly. The data is changed mid-write, both with the update strobe held low and with an update released in the same cycle as the write ends. The first pattern separates transparent tracking from edge capture. The second pattern separates a correct guard window from a plain level-sensitive update.

// File: rtl/dual_dac_regs.sv
module dual_dac_regs #(
  parameter int BUS_W       = 8,
  parameter int HI_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_UPD_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_n,
  input  logic                 bus_wr_n,
  input  logic [1:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_data,
  input  logic                 upd_n,
  output logic [BUS_W+HI_W-1:0] chan_a,
  output logic [BUS_W+HI_W-1:0] chan_b
);
  localparam int CW    = BUS_W + HI_W;
  localparam int PIN_W = BUS_W + 5;
  localparam int CNT_W = $clog2(MIN_UPD_CYC + 1);

  logic [SYNC_STAGES-1:0][PIN_W-1:0] sync_q;
  logic [PIN_W-1:0] pins;
  logic             s_sel_n, s_wr_n, s_upd_n;
  logic [1:0]       s_addr;
  logic [BUS_W-1:0] s_data;
  logic [CW-1:0]    in_a, in_b;
  logic [CNT_W-1:0] hold_cnt;
  logic             wr_act, upd_eff;

  assign pins = {upd_n, bus_sel_n, bus_wr_n, bus_addr, bus_data};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{ {3'b111, {(PIN_W-3){1'b0}}} }};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pins};
  end

  assign {s_upd_n, s_sel_n, s_wr_n, s_addr, s_data} = sync_q[SYNC_STAGES-1];
  assign wr_act  = !s_sel_n && !s_wr_n;
  assign upd_eff = !s_upd_n || (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_a <= '0;
      in_b <= '0;
    end else if (wr_act) begin
      case (s_addr)
        2'b00: in_a[BUS_W-1:0]  <= s_data;
        2'b01: in_a[CW-1:BUS_W] <= s_data[HI_W-1:0];
        2'b10: in_b[BUS_W-1:0]  <= s_data;
        default: in_b[CW-1:BUS_W] <= s_data[HI_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 hold_cnt <= '0;
    else if (!s_upd_n && wr_act) hold_cnt <= CNT_W'(MIN_UPD_CYC);
    else if (hold_cnt != '0)     hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_a <= '0;
      chan_b <= '0;
    end else if (upd_eff) begin
      chan_a <= in_a;
      chan_b <= in_b;
    end
  end
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int BUS_W = 8,
  parameter int CW    = 12,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_upd_n,
  input logic             wr_act,
  input logic [1:0]       s_addr,
  input logic [BUS_W-1:0] s_data,
  input logic [CNT_W-1:0] hold_cnt,
  input logic [CW-1:0]    in_a,
  input logic [CW-1:0]    in_b,
  input logic [CW-1:0]    chan_a,
  input logic [CW-1:0]    chan_b
);
  p_addr_low_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && s_addr == 2'b00) |=> (in_a[BUS_W-1:0] == $past(s_data)) && $stable(in_b));

  p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> $stable(in_a) && $stable(in_b));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_upd_n && hold_cnt == '0) |=> $stable(chan_a) && $stable(chan_b));

  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s_upd_n |=> (chan_a == $past(in_a)) && (chan_b == $past(in_b)));

  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(s_upd_n) && $past(wr_act)) |=> (chan_a == $past(in_a)) && (chan_b == $past(in_b)));
endmodule

bind dual_dac_regs dual_dac_regs_chk #(.BUS_W(BUS_W), .CW(CW), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .s_upd_n(s_upd_n), .wr_act(wr_act), .s_addr(s_addr),
  .s_data(s_data), .hold_cnt(hold_cnt), .in_a(in_a), .in_b(in_b),
  .chan_a(chan_a), .chan_b(chan_b)
);

// File: tb/dual_dac_regs_test.sv
module dual_dac_regs_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel_n = 1, bus_wr_n = 1, upd_n = 1;
  logic [1:0]  bus_addr = 0;
  logic [7:0]  bus_data = 0;
  logic [11:0] chan_a, chan_b;
  int checks = 0, errors = 0;
  bit done = 0;

  dual_dac_regs uut (.clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .upd_n(upd_n), .chan_a(chan_a), .chan_b(chan_b));

  always #5 clk = ~clk;

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_sel_n = 0; bus_wr_n = 0;
    cyc(3);
    bus_sel_n = 1; bus_wr_n = 1;
    cyc(2);
  endtask

  task automatic pulse_update();
    @(negedge clk); upd_n = 0;
    cyc(6);
    upd_n = 1;
    cyc(10);
  endtask

  task automatic t_reset();
    check("R8 chan_a", chan_a, 12'h000);
    check("R8 chan_b", chan_b, 12'h000);
  endtask

  task automatic t_load_orders();
    bus_write(2'b00, 8'h34);
    bus_write(2'b01, 8'hF2);
    bus_write(2'b11, 8'h0A);
    bus_write(2'b10, 8'hBC);
    cyc(6);
    check("R5 chan_a before update", chan_a, 12'h000);
    check("R5 chan_b before update", chan_b, 12'h000);
    pulse_update();
    check("R1 R3 chan_a", chan_a, 12'h234);
    check("R1 R5 chan_b", chan_b, 12'hABC);
  endtask

  task automatic t_gated();
    @(negedge clk);
    bus_addr = 2'b00; bus_data = 8'h99; bus_sel_n = 1; bus_wr_n = 0;
    cyc(4);
    bus_addr = 2'b11; bus_data = 8'h07; bus_sel_n = 0; bus_wr_n = 1;
    cyc(4);
    bus_sel_n = 1; bus_wr_n = 1;
    pulse_update();
    check("R4 chan_a", chan_a, 12'h234);
    check("R4 chan_b", chan_b, 12'hABC);
  endtask

  task automatic t_hold();
    bus_write(2'b00, 8'h55);
    bus_write(2'b11, 8'h01);
    cyc(8);
    check("R6 chan_a held", chan_a, 12'h234);
    check("R6 chan_b held", chan_b, 12'hABC);
    pulse_update();
    check("R6 chan_a after update", chan_a, 12'h255);
    check("R6 chan_b after update", chan_b, 12'h1BC);
  endtask

  task automatic t_transparent();
    @(negedge clk); upd_n = 0;
    cyc(6);
    bus_addr = 2'b10; bus_data = 8'h11; bus_sel_n = 0; bus_wr_n = 0;
    cyc(4);
    check("R7 chan_b follows", chan_b, 12'h111);
    bus_data = 8'h22;
    cyc(4);
    check("R2 chan_b follows second", chan_b, 12'h122);
    bus_sel_n = 1; bus_wr_n = 1; bus_data = 8'h77;
    cyc(6);
    check("R2 chan_b keeps last", chan_b, 12'h122);
    upd_n = 1;
    cyc(10);
  endtask

  task automatic t_guard();
    @(negedge clk);
    upd_n = 0; bus_addr = 2'b00; bus_data = 8'h61; bus_sel_n = 0; bus_wr_n = 0;
    cyc(4);
    bus_data = 8'h6E;
    cyc(1);
    upd_n = 1; bus_sel_n = 1; bus_wr_n = 1;
    cyc(10);
    check("R9 chan_a last byte captured", chan_a, 12'h26E);
    bus_write(2'b00, 8'h33);
    cyc(6);
    check("R9 R6 chan_a held after window", chan_a, 12'h26E);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(4);
    t_reset();
    t_load_orders();
    t_gated();
    t_hold();
    t_transparent();
    t_guard();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule